// File: doc/BRIEF.md
# Two-Level Interrupt Router

This block steers level-sensitive interrupt sources to a small group of processors, at most four. A source reaches a core only after passing two gates. The first is a single enable bit per source that all cores share. The second is a mask bit kept separately by each core. A shared source must also carry a routing bit for that core. Software changes enable and mask state by writing a source index to a set register or a clear register. It never needs a read-modify-write, so cores do not race each other.

Each bus access picks one of two windows. The shared window holds the enable set and clear registers, one control word per source and a read-only word that reports how many sources exist. The per-core window is addressed by a core identifier that comes with every access. It holds mask set and clear registers and an acknowledge register. Reading the acknowledge register returns the lowest-numbered source currently pending for that core, or 1023 when none is pending. The lowest source numbers are private: each core has its own copy of such a source on its own input lines. Each core has one interrupt output.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every source is disabled at the shared level and masked on every core. Every source control word reads 0x1, meaning routed to core 0 with no fast-route bits. `irq_out` is all zero and an acknowledge read returns 1023.
- R2: Writing a source index to shared offset 0x30 enables that source, and writing it to 0x34 disables it. An index at or above NUM_SRC changes nothing.
- R3: Writing a source index to per-core offset 0x48 masks that source, and writing it to 0x4C unmasks it. The change applies only to the bank chosen by `bus_cpu`.
- R4: A shared source n (n >= NUM_PRIV) drives `irq_out[c]` only while its input is high, it is enabled, bit c of its control word is set and core c does not mask it. The output falls when the input falls.
- R5: Private source n (n < NUM_PRIV) for core c is taken from `priv_irq[c*NUM_PRIV+n]` and never affects another core. Its routing bits have no effect.
- R6: A read of per-core offset 0x44 returns, in bits [9:0], the lowest eligible source for that core, or 1023 when none is eligible. Upper bits read zero and the read has no side effect.
- R7: Shared offset 0x00 reads NUM_SRC in bits [11:2] and zero elsewhere.
- R8: The source control word at shared offset 0x100+4n holds IRQ routing in bits [3:0] and fast-route bits in [11:8], one bit per core in each field. Both fields read back as written. The fast-route bits have no effect on `irq_out`.
- R9: Read data appears with `rd_valid` exactly one cycle after the read request. `irq_out` is registered and follows inputs and register state one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_percpu | input | 1 | 1 = per-core window, 0 = shared window |
| bus_cpu | input | 2 | Core issuing the access; selects the per-core bank |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data (source index or control word) |
| glob_irq | input | NUM_SRC-NUM_PRIV (35) | Level inputs of shared sources NUM_PRIV..NUM_SRC-1 |
| priv_irq | input | NUM_CPU*NUM_PRIV (116) | Level inputs of private sources, NUM_PRIV per core |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq_out | output | NUM_CPU (4) | Interrupt line to each core |

## Verification
The bench targets the points where the two gates can disagree. It enables a source that is still masked, unmasks it on a core it is not routed to, and drops the input while both gates are open. A design that checks only one gate, or latches the level, would raise or hold a line that should stay low. Other cases catch a mask write that lands in the wrong core's bank and an out-of-range index that corrupts a real source. Private inputs are raised on one core and watched for leakage onto another core. The acknowledge read is checked against lowest-first selection, both while a higher-numbered shared source is pending and after pending sources go away. A wrong encoder returns the higher number, and a read with side effects changes the result of the second read. A sample one delta after an input change makes sure the output is registered and not combinational.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

    localparam int MAX_CPU = 4;
    localparam int CPU_W   = 2;
    localparam int IDX_W   = 10;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;

    localparam logic [IDX_W-1:0] NO_PENDING = 10'd1023;

    // shared window
    localparam logic [ADDR_W-1:0] OFS_CTRLWORD = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_EN_SET   = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_SRC_BASE = 12'h100;
    // per-core window
    localparam logic [ADDR_W-1:0] OFS_ACK      = 12'h044;
    localparam logic [ADDR_W-1:0] OFS_MSK_SET  = 12'h048;
    localparam logic [ADDR_W-1:0] OFS_MSK_CLR  = 12'h04C;

    typedef enum logic [2:0] {
        OP_NONE, OP_EN_SET, OP_EN_CLR, OP_MSK_SET, OP_MSK_CLR, OP_CTL_WR
    } wr_op_e;

    typedef enum logic [1:0] {
        RD_ZERO, RD_CTRLWORD, RD_ACK, RD_SRCCTL
    } rd_sel_e;

    typedef struct packed {
        logic [MAX_CPU-1:0] fiq;
        logic [MAX_CPU-1:0] irq;
    } src_ctl_t;

    typedef struct packed {
        wr_op_e             op;
        logic [IDX_W-1:0]   idx;
        logic [CPU_W-1:0]   cpu;
        src_ctl_t           ctl;
    } wr_cmd_t;

    function automatic logic [DATA_W-1:0] pack_ctl(src_ctl_t c);
        return {20'b0, c.fiq, 4'b0, c.irq};
    endfunction

    function automatic src_ctl_t unpack_ctl(logic [11:0] d);
        src_ctl_t c;
        c.irq = d[3:0];
        c.fiq = d[11:8];
        return c;
    endfunction

endpackage

// File: rtl/irq_rt_decode.sv
module irq_rt_decode
    import irq_rt_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 64
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic              bus_percpu,
    input  logic [CPU_W-1:0]  bus_cpu,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output wr_cmd_t           wr,
    output rd_sel_e           rsel,
    output logic [IDX_W-1:0]  ridx
);
    localparam logic [ADDR_W-1:0] CTL_END = ADDR_W'(256 + 4 * NUM_SRC);

    logic             idx_ok;
    logic             ctl_hit;
    logic             cpu_ok;
    logic [IDX_W-1:0] ctl_idx;
    logic [ADDR_W-1:0] ctl_off;

    always_comb begin
        idx_ok  = bus_wdata < DATA_W'(NUM_SRC);
        cpu_ok  = {1'b0, bus_cpu} < (CPU_W + 1)'(NUM_CPU);
        ctl_hit = !bus_percpu && (bus_addr >= OFS_SRC_BASE) &&
                  (bus_addr < CTL_END) && (bus_addr[1:0] == 2'b00);
        ctl_off = bus_addr - OFS_SRC_BASE;
        ctl_idx = IDX_W'(ctl_off[ADDR_W-1:2]);

        wr.op  = OP_NONE;
        wr.idx = bus_wdata[IDX_W-1:0];
        wr.cpu = bus_cpu;
        wr.ctl = unpack_ctl(bus_wdata[11:0]);
        rsel   = RD_ZERO;
        ridx   = ctl_idx;

        if (bus_valid && bus_write) begin
            if (!bus_percpu) begin
                if (bus_addr == OFS_EN_SET && idx_ok)      wr.op = OP_EN_SET;
                else if (bus_addr == OFS_EN_CLR && idx_ok) wr.op = OP_EN_CLR;
                else if (ctl_hit) begin
                    wr.op  = OP_CTL_WR;
                    wr.idx = ctl_idx;
                end
            end else if (cpu_ok && idx_ok) begin
                if (bus_addr == OFS_MSK_SET)      wr.op = OP_MSK_SET;
                else if (bus_addr == OFS_MSK_CLR) wr.op = OP_MSK_CLR;
            end
        end

        if (bus_valid && !bus_write) begin
            if (!bus_percpu) begin
                if (bus_addr == OFS_CTRLWORD) rsel = RD_CTRLWORD;
                else if (ctl_hit)             rsel = RD_SRCCTL;
            end else if (cpu_ok && bus_addr == OFS_ACK) begin
                rsel = RD_ACK;
            end
        end
    end
endmodule

// File: rtl/irq_rt_state.sv
module irq_rt_state
    import irq_rt_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 64
) (
    input  logic                              clk,
    input  logic                              rst,
    input  wr_cmd_t                           wr,
    output logic [NUM_SRC-1:0]                en_q,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]   msk_q,
    output src_ctl_t [NUM_SRC-1:0]            ctl_q
);
    localparam logic [MAX_CPU-1:0] CPU_LIVE = MAX_CPU'((1 << NUM_CPU) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            msk_q <= '1;
            for (int n = 0; n < NUM_SRC; n++) begin
                ctl_q[n].irq <= MAX_CPU'(1);
                ctl_q[n].fiq <= '0;
            end
        end else begin
            for (int n = 0; n < NUM_SRC; n++) begin
                if (wr.idx == IDX_W'(n)) begin
                    case (wr.op)
                        OP_EN_SET: en_q[n] <= 1'b1;
                        OP_EN_CLR: en_q[n] <= 1'b0;
                        OP_CTL_WR: begin
                            ctl_q[n].irq <= wr.ctl.irq & CPU_LIVE;
                            ctl_q[n].fiq <= wr.ctl.fiq & CPU_LIVE;
                        end
                        default: ;
                    endcase
                    for (int c = 0; c < NUM_CPU; c++) begin
                        if (wr.cpu == CPU_W'(c)) begin
                            if (wr.op == OP_MSK_SET) msk_q[c][n] <= 1'b1;
                            if (wr.op == OP_MSK_CLR) msk_q[c][n] <= 1'b0;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/irq_rt_select.sv
module irq_rt_select
    import irq_rt_pkg::*;
#(
    parameter int NUM_CPU  = 4,
    parameter int NUM_SRC  = 64,
    parameter int NUM_PRIV = 29
) (
    input  logic [NUM_SRC-1:NUM_PRIV]         glob_irq,
    input  logic [NUM_CPU*NUM_PRIV-1:0]       priv_irq,
    input  logic [NUM_SRC-1:0]                en_q,
    input  logic [NUM_CPU-1:0][NUM_SRC-1:0]   msk_q,
    input  src_ctl_t [NUM_SRC-1:0]            ctl_q,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]   elig,
    output logic [NUM_CPU-1:0][IDX_W-1:0]     pick,
    output logic [NUM_CPU-1:0]                any_pend
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            if (s < NUM_PRIV) begin : g_priv
                assign elig[c][s] = priv_irq[c*NUM_PRIV + s] & en_q[s] & ~msk_q[c][s];
            end else begin : g_shared
                assign elig[c][s] = glob_irq[s] & en_q[s] & ctl_q[s].irq[c] & ~msk_q[c][s];
            end
        end

        always_comb begin
            pick[c] = NO_PENDING;
            for (int s = NUM_SRC - 1; s >= 0; s--) begin
                if (elig[c][s]) pick[c] = IDX_W'(s);
            end
        end

        assign any_pend[c] = |elig[c];
    end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_rt_pkg::*;
#(
    parameter int NUM_CPU  = 4,
    parameter int NUM_SRC  = 64,
    parameter int NUM_PRIV = 29
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic                         bus_percpu,
    input  logic [CPU_W-1:0]             bus_cpu,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    input  logic [NUM_SRC-1:NUM_PRIV]    glob_irq,
    input  logic [NUM_CPU*NUM_PRIV-1:0]  priv_irq,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    output logic [NUM_CPU-1:0]           irq_out
);
    wr_cmd_t                            wr;
    rd_sel_e                            rsel;
    logic [IDX_W-1:0]                   ridx;
    logic [NUM_SRC-1:0]                 en_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]    msk_q;
    src_ctl_t [NUM_SRC-1:0]             ctl_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]    elig;
    logic [NUM_CPU-1:0][IDX_W-1:0]      pick;
    logic [NUM_CPU-1:0]                 any_pend;
    logic [DATA_W-1:0]                  rd_mux;

    irq_rt_decode #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_percpu(bus_percpu),
        .bus_cpu   (bus_cpu),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr        (wr),
        .rsel      (rsel),
        .ridx      (ridx)
    );

    irq_rt_state #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_state (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .en_q (en_q),
        .msk_q(msk_q),
        .ctl_q(ctl_q)
    );

    irq_rt_select #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC), .NUM_PRIV(NUM_PRIV)) u_sel (
        .glob_irq(glob_irq),
        .priv_irq(priv_irq),
        .en_q    (en_q),
        .msk_q   (msk_q),
        .ctl_q   (ctl_q),
        .elig    (elig),
        .pick    (pick),
        .any_pend(any_pend)
    );

    always_comb begin
        rd_mux = '0;
        case (rsel)
            RD_CTRLWORD: rd_mux = {20'b0, IDX_W'(NUM_SRC), 2'b00};
            RD_ACK: begin
                for (int c = 0; c < NUM_CPU; c++)
                    if (bus_cpu == CPU_W'(c)) rd_mux = {22'b0, pick[c]};
            end
            RD_SRCCTL: begin
                for (int n = 0; n < NUM_SRC; n++)
                    if (ridx == IDX_W'(n)) rd_mux = pack_ctl(ctl_q[n]);
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            irq_out  <= '0;
        end else begin
            rd_valid <= bus_valid && !bus_write;
            rd_data  <= rd_mux;
            irq_out  <= any_pend;
        end
    end
endmodule

// File: rtl/irq_rt_chk.sv
module irq_rt_chk
    import irq_rt_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 64
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            bus_valid,
    input logic                            bus_write,
    input logic                            bus_percpu,
    input logic [CPU_W-1:0]                bus_cpu,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [DATA_W-1:0]               bus_wdata,
    input logic                            rd_valid,
    input logic [DATA_W-1:0]               rd_data,
    input logic [NUM_CPU-1:0]              irq_out,
    input logic [NUM_SRC-1:0]              en_q,
    input logic [NUM_CPU-1:0][NUM_SRC-1:0] msk_q,
    input logic [NUM_CPU-1:0][NUM_SRC-1:0] elig
);
    localparam int SRC_W = $clog2(NUM_SRC);

    logic rd_req, ack_req, cw_req, mset_req;
    assign rd_req   = bus_valid && !bus_write;
    assign ack_req  = rd_req && bus_percpu && bus_addr == OFS_ACK;
    assign cw_req   = rd_req && !bus_percpu && bus_addr == OFS_CTRLWORD;
    assign mset_req = bus_valid && bus_write && bus_percpu && bus_addr == OFS_MSK_SET &&
                      bus_wdata < DATA_W'(NUM_SRC) && {1'b0, bus_cpu} < (CPU_W + 1)'(NUM_CPU);

    // R9
    rd_resp_chk: assert property (@(posedge clk) disable iff (rst) rd_req |=> rd_valid);
    // R9
    no_stray_rd_chk: assert property (@(posedge clk) disable iff (rst) !rd_req |=> !rd_valid);
    // R7
    ctrlword_chk: assert property (@(posedge clk) disable iff (rst)
        cw_req |=> rd_data == DATA_W'(NUM_SRC << 2));
    // R6
    ack_range_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> (rd_data[31:10] == '0) &&
                    (rd_data[9:0] == NO_PENDING || rd_data[9:0] < IDX_W'(NUM_SRC)));
    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        mset_req |=> msk_q[$past(bus_cpu)][$past(bus_wdata[SRC_W-1:0])]);

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        // R2
        en_gate_chk: assert property (@(posedge clk) disable iff (rst)
            (elig[c] & ~en_q) == '0);
        // R4
        out_gate_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(irq_out[c]) |-> $past((en_q & ~msk_q[c]) != '0));
    end
endmodule

bind irq_route_ctrl irq_rt_chk #(.NUM_CPU(NUM_CPU), .NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_percpu(bus_percpu),
    .bus_cpu   (bus_cpu),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .irq_out   (irq_out),
    .en_q      (en_q),
    .msk_q     (msk_q),
    .elig      (elig)
);

// File: tb/sim_irq_route_ctrl.sv
module sim_irq_route_ctrl;
    import irq_rt_pkg::*;

    localparam int NC = 4;
    localparam int NS = 64;
    localparam int NP = 29;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst = 1'b1;
    logic              bus_valid = 1'b0, bus_write = 1'b0, bus_percpu = 1'b0;
    logic [CPU_W-1:0]  bus_cpu = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [NS-1:NP]    glob_irq = '0;
    logic [NC*NP-1:0]  priv_irq = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [NC-1:0]     irq_out;

    irq_route_ctrl #(.NUM_CPU(NC), .NUM_SRC(NS), .NUM_PRIV(NP)) u0 (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_percpu(bus_percpu), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .glob_irq(glob_irq), .priv_irq(priv_irq),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_out(irq_out)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic pc, logic [1:0] cpu, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_percpu = pc;
        bus_cpu = cpu; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    // driver: issues the read and queues the expected response
    task automatic rd(logic pc, logic [1:0] cpu, logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_percpu = pc;
        bus_cpu = cpu; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic irq_is(logic [3:0] exp, string tag);
        @(negedge clk);
        check(tag, {28'b0, irq_out}, {28'b0, exp});
    endtask

    // monitor: pops expected items as responses arrive
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R9 unexpected response: actual %0h expected none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        irq_is(4'b0000, "R1 irq after reset");
        rd(1, 0, 12'h044, 32'h3FF, "R1 ack after reset");
        rd(0, 0, 12'h1A0, 32'h1, "R1 ctl40 reset route");
        rd(0, 0, 12'h000, 32'h100, "R7 ctrl word");

        // R4 both gates needed
        glob_irq[40] = 1'b1;
        wr(0, 0, 12'h030, 40);
        irq_is(4'b0000, "R4 enabled but masked");
        wr(1, 0, 12'h04C, 40);
        irq_is(4'b0001, "R4 enabled unmasked routed");
        rd(1, 0, 12'h044, 40, "R6 ack cpu0");
        rd(1, 1, 12'h044, 32'h3FF, "R3 cpu1 bank untouched");

        // routing
        wr(0, 0, 12'h1A0, 32'h4);
        irq_is(4'b0000, "R4 rerouted to masked cpu2");
        wr(1, 2, 12'h04C, 40);
        irq_is(4'b0100, "R4 cpu2 unmasked");
        wr(0, 0, 12'h1A0, 32'h304);
        irq_is(4'b0100, "R8 fast-route bits no effect");
        rd(0, 0, 12'h1A0, 32'h304, "R8 ctl readback");

        // level behaviour
        glob_irq[40] = 1'b0;
        irq_is(4'b0000, "R4 input low");
        glob_irq[40] = 1'b1;
        irq_is(4'b0100, "R4 input high again");

        // global enable
        wr(0, 0, 12'h034, 40);
        irq_is(4'b0000, "R2 disabled");
        wr(0, 0, 12'h030, 100);
        rd(1, 2, 12'h044, 32'h3FF, "R2 out of range enable ignored");
        wr(0, 0, 12'h030, 40);
        irq_is(4'b0100, "R2 re-enabled");

        // per-core mask set
        wr(1, 2, 12'h048, 40);
        irq_is(4'b0000, "R3 mask set cpu2");
        rd(1, 2, 12'h044, 32'h3FF, "R3 ack after mask");

        // private sources
        priv_irq[1*NP+5] = 1'b1;
        wr(0, 0, 12'h030, 5);
        wr(1, 1, 12'h04C, 5);
        irq_is(4'b0010, "R5 private to cpu1");
        wr(1, 3, 12'h04C, 5);
        irq_is(4'b0010, "R5 cpu3 own input low");
        wr(0, 0, 12'h114, 32'h0);
        irq_is(4'b0010, "R5 routing ignored");

        // lowest-first acknowledge
        glob_irq[50] = 1'b1;
        wr(0, 0, 12'h030, 50);
        wr(0, 0, 12'h1C8, 32'h2);
        wr(1, 1, 12'h04C, 50);
        rd(1, 1, 12'h044, 5, "R6 lowest of 5 and 50");
        priv_irq[1*NP+3] = 1'b1;
        wr(0, 0, 12'h030, 3);
        wr(1, 1, 12'h04C, 3);
        rd(1, 1, 12'h044, 3, "R6 lowest is 3");
        rd(1, 1, 12'h044, 3, "R6 read has no side effect");
        priv_irq[1*NP+3] = 1'b0;
        priv_irq[1*NP+5] = 1'b0;
        rd(1, 1, 12'h044, 50, "R6 falls back to 50");
        irq_is(4'b0010, "R4 cpu1 via 50");

        // output latency
        @(negedge clk);
        glob_irq[50] = 1'b0;
        #1 check("R9 output registered", {28'b0, irq_out}, 32'h2);
        @(negedge clk);
        check("R9 output after one edge", {28'b0, irq_out}, 32'h0);

        // private input of cpu3
        priv_irq[3*NP+5] = 1'b1;
        irq_is(4'b1000, "R5 cpu3 private input");
        glob_irq[29] = 1'b1;
        wr(0, 0, 12'h030, 29);
        wr(1, 0, 12'h04C, 29);
        irq_is(4'b1001, "R4 first shared source");
        rd(1, 0, 12'h044, 29, "R6 ack source 29");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R9 missing responses: actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule